// File: doc/BRIEF.md
# AC-link Output Frame Transmitter

This block is the controller-side serializer of an AC-link. Running on the incoming bit clock, it produces the frame sync and the serial output data. Every frame is 256 bit clocks long: a 16-bit tag phase followed by twelve 20-bit slots. At a 12.288 MHz bit clock this gives a 48 kHz frame rate. The block builds the tag from per-slot valid flags and then shifts the whole frame out, most significant bit first.

At the start of each frame the block captures one codec command, the left and right PCM samples and two digital-audio-out channel samples. The command has an address, data and a read/write selector. Each of the other inputs has its own valid flag. The block raises a one-cycle ready pulse as it captures these inputs, and the source may then present the next frame's values. Slots with no valid data are driven as zero, and so are the slots that this block never uses.

Top module: `ac_link_tx`

## Requirements
- R1: While rst_ni is low, sync_o, sdata_o and ready_o are 0. The first rising clock edge after reset release starts a frame, and sync_o is 1 after that edge.
- R2: A frame lasts 256 rising edges. sync_o is 1 for the first 16 of them and 0 for the remaining 240.
- R3: Frame bit k, counted from 0 at the tag MSB, appears on sdata_o after the (k+1)-th rising edge that follows the edge raising sync_o. The tag valid bit therefore comes exactly one clock after sync_o rises, and every field goes out MSB first.
- R4: Tag bit 15 (the first bit sent) is 1 when any of the six slot flags in R5 is 1, and 0 otherwise.
- R5: Tag bit 14 flags the command address (slot 1) and bit 13 flags the command data (slot 2). Bits 12 and 11 flag left and right PCM (slots 3 and 4). Bits 8 and 7 flag digital-out channels A and B (slots 7 and 8). Tag bits 10, 9 and 6 to 0 are always 0.
- R6: Slot 1 for a valid command is {read flag in bit 19 (1 = read), address in bits 18:12, zeros in bits 11:0}. Slot 1 is all zero when no command is valid.
- R7: Slot 2 for a valid write command holds the 16 data bits in bits 19:4 with bits 3:0 zero. For a read command or when no command is valid, tag bit 13 is 0 and slot 2 is all zero.
- R8: Slots 3, 4, 7 and 8 carry left PCM, right PCM, digital A and digital B as 20-bit values when the matching flag is 1, and are all zero when it is 0.
- R9: Slots 5, 6, 9, 10, 11 and 12 are always all zero.
- R10: The inputs are sampled only at the rising edge that raises sync_o. ready_o is 1 for exactly the cycle after that edge. Input changes at any other time do not affect the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; all outputs change on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is present for the next frame |
| cmd_read_i | input | 1 | 1 = register read, 0 = register write |
| cmd_addr_i | input | 7 | Command register address |
| cmd_data_i | input | 16 | Command write data |
| pcm_l_valid_i | input | 1 | Left PCM sample valid |
| pcm_l_i | input | 20 | Left PCM sample |
| pcm_r_valid_i | input | 1 | Right PCM sample valid |
| pcm_r_i | input | 20 | Right PCM sample |
| dig_a_valid_i | input | 1 | Digital-out channel A sample valid |
| dig_a_i | input | 20 | Digital-out channel A sample |
| dig_b_valid_i | input | 1 | Digital-out channel B sample valid |
| dig_b_i | input | 20 | Digital-out channel B sample |
| ready_o | output | 1 | One-cycle pulse: inputs were captured; next frame's values may be presented |
| sync_o | output | 1 | Frame sync, high during the tag phase |
| sdata_o | output | 1 | Serial frame data |

## Verification
The hardest case to reach from the ports is an input change that lands mid-frame and must have no effect. The bench scrambles every input about 100 bit clocks into each frame and restores the intended pattern around clock 200, so every frame is sent while the inputs hold unrelated values. The tag valid bit raised by only the last flag (bit 7) is another case that ordinary traffic does not produce. So is a read command, which must suppress slot 2 even though data is present. Directed frames cover both before randomized flag patterns take over.

// File: rtl/ac_link_tx_pkg.sv
`timescale 1ns/1ps
package ac_link_tx_pkg;
  localparam int TB_VALID = 15;
  localparam int TB_CMD   = 14;
  localparam int TB_CDATA = 13;
  localparam int TB_LEFT  = 12;
  localparam int TB_RIGHT = 11;
  localparam int TB_DIG_A = 8;
  localparam int TB_DIG_B = 7;

  localparam int SL_CMD   = 1;
  localparam int SL_CDATA = 2;
  localparam int SL_LEFT  = 3;
  localparam int SL_RIGHT = 4;
  localparam int SL_DIG_A = 7;
  localparam int SL_DIG_B = 8;

  typedef struct packed {
    logic cmd;
    logic cmd_wr;
    logic left;
    logic right;
    logic dig_a;
    logic dig_b;
  } slot_flags_t;
endpackage

// File: rtl/ac_link_tx_tag.sv
`timescale 1ns/1ps
module ac_link_tx_tag
  import ac_link_tx_pkg::*;
#(
  parameter int TAG_W = 16
) (
  input  slot_flags_t      flags_i,
  output logic [TAG_W-1:0] tag_o
);
  always_comb begin
    tag_o           = '0;
    tag_o[TB_CMD]   = flags_i.cmd;
    tag_o[TB_CDATA] = flags_i.cmd_wr;
    tag_o[TB_LEFT]  = flags_i.left;
    tag_o[TB_RIGHT] = flags_i.right;
    tag_o[TB_DIG_A] = flags_i.dig_a;
    tag_o[TB_DIG_B] = flags_i.dig_b;
    tag_o[TB_VALID] = |flags_i;
  end
endmodule

// File: rtl/ac_link_tx_pack.sv
`timescale 1ns/1ps
module ac_link_tx_pack
  import ac_link_tx_pkg::*;
#(
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 12,
  parameter int ADDR_W  = 7,
  parameter int CDATA_W = 16,
  localparam int FRAME_W = TAG_W + N_SLOTS * SLOT_W
) (
  input  slot_flags_t        flags_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic               cmd_read_i,
  input  logic [ADDR_W-1:0]  cmd_addr_i,
  input  logic [CDATA_W-1:0] cmd_data_i,
  input  logic [SLOT_W-1:0]  pcm_l_i,
  input  logic [SLOT_W-1:0]  pcm_r_i,
  input  logic [SLOT_W-1:0]  dig_a_i,
  input  logic [SLOT_W-1:0]  dig_b_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int ADDR_PAD  = SLOT_W - 1 - ADDR_W;
  localparam int CDATA_PAD = SLOT_W - CDATA_W;

  logic [SLOT_W-1:0] slot_w [1:N_SLOTS];

  assign frame_o[FRAME_W-1 -: TAG_W] = tag_i;

  for (genvar s = 1; s <= N_SLOTS; s++) begin : g_slot
    localparam int HI = FRAME_W - 1 - TAG_W - (s - 1) * SLOT_W;
    if (s == SL_CMD) begin : g_cmd
      assign slot_w[s] = flags_i.cmd ? {cmd_read_i, cmd_addr_i, {ADDR_PAD{1'b0}}} : '0;
    end else if (s == SL_CDATA) begin : g_cdata
      assign slot_w[s] = flags_i.cmd_wr ? {cmd_data_i, {CDATA_PAD{1'b0}}} : '0;
    end else if (s == SL_LEFT) begin : g_left
      assign slot_w[s] = flags_i.left ? pcm_l_i : '0;
    end else if (s == SL_RIGHT) begin : g_right
      assign slot_w[s] = flags_i.right ? pcm_r_i : '0;
    end else if (s == SL_DIG_A) begin : g_dig_a
      assign slot_w[s] = flags_i.dig_a ? dig_a_i : '0;
    end else if (s == SL_DIG_B) begin : g_dig_b
      assign slot_w[s] = flags_i.dig_b ? dig_b_i : '0;
    end else begin : g_zero
      assign slot_w[s] = '0;
    end
    assign frame_o[HI -: SLOT_W] = slot_w[s];
  end
endmodule

// File: rtl/ac_link_tx_timing.sv
`timescale 1ns/1ps
module ac_link_tx_timing #(
  parameter int FRAME_W = 256,
  parameter int SYNC_W  = 16,
  localparam int CNT_W  = $clog2(FRAME_W)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o,
  output logic sync_o,
  output logic ready_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  // position of the bit that sync_o currently marks; LAST after reset so the first edge opens a frame
  assign load_o  = (cnt_q == LAST);
  assign cnt_nxt = load_o ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= LAST;
      sync_o  <= 1'b0;
      ready_o <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      sync_o  <= (cnt_nxt < CNT_W'(SYNC_W));
      ready_o <= load_o;
    end
  end
endmodule

// File: rtl/ac_link_tx_shift.sv
`timescale 1ns/1ps
module ac_link_tx_shift #(
  parameter int FRAME_W = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sdata_o
);
  logic [FRAME_W-1:0] frame_q;

  // sdata lags the load by one edge: the tag MSB follows the sync rise by one clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      sdata_o <= 1'b0;
    end else begin
      sdata_o <= frame_q[FRAME_W-1];
      frame_q <= load_i ? frame_i : {frame_q[FRAME_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/ac_link_tx.sv
`timescale 1ns/1ps
module ac_link_tx
  import ac_link_tx_pkg::*;
#(
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 12,
  parameter int ADDR_W  = 7,
  parameter int CDATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic               cmd_read_i,
  input  logic [ADDR_W-1:0]  cmd_addr_i,
  input  logic [CDATA_W-1:0] cmd_data_i,
  input  logic               pcm_l_valid_i,
  input  logic [SLOT_W-1:0]  pcm_l_i,
  input  logic               pcm_r_valid_i,
  input  logic [SLOT_W-1:0]  pcm_r_i,
  input  logic               dig_a_valid_i,
  input  logic [SLOT_W-1:0]  dig_a_i,
  input  logic               dig_b_valid_i,
  input  logic [SLOT_W-1:0]  dig_b_i,
  output logic               ready_o,
  output logic               sync_o,
  output logic               sdata_o
);
  localparam int FRAME_W = TAG_W + N_SLOTS * SLOT_W;

  slot_flags_t        flags;
  logic [TAG_W-1:0]   tag;
  logic [FRAME_W-1:0] frame;
  logic               load;

  assign flags.cmd    = cmd_valid_i;
  assign flags.cmd_wr = cmd_valid_i & ~cmd_read_i;
  assign flags.left   = pcm_l_valid_i;
  assign flags.right  = pcm_r_valid_i;
  assign flags.dig_a  = dig_a_valid_i;
  assign flags.dig_b  = dig_b_valid_i;

  ac_link_tx_tag #(.TAG_W(TAG_W)) u_tag (
    .flags_i (flags),
    .tag_o   (tag)
  );

  ac_link_tx_pack #(
    .TAG_W   (TAG_W),
    .SLOT_W  (SLOT_W),
    .N_SLOTS (N_SLOTS),
    .ADDR_W  (ADDR_W),
    .CDATA_W (CDATA_W)
  ) u_pack (
    .flags_i    (flags),
    .tag_i      (tag),
    .cmd_read_i (cmd_read_i),
    .cmd_addr_i (cmd_addr_i),
    .cmd_data_i (cmd_data_i),
    .pcm_l_i    (pcm_l_i),
    .pcm_r_i    (pcm_r_i),
    .dig_a_i    (dig_a_i),
    .dig_b_i    (dig_b_i),
    .frame_o    (frame)
  );

  ac_link_tx_timing #(.FRAME_W(FRAME_W), .SYNC_W(TAG_W)) u_timing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_o  (load),
    .sync_o  (sync_o),
    .ready_o (ready_o)
  );

  ac_link_tx_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .frame_i (frame),
    .sdata_o (sdata_o)
  );
endmodule

// File: rtl/ac_link_tx_chk.sv
`timescale 1ns/1ps
module ac_link_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic cmd_read_i,
  input logic pcm_l_valid_i,
  input logic pcm_r_valid_i,
  input logic dig_a_valid_i,
  input logic dig_b_valid_i,
  input logic ready_o,
  input logic sync_o,
  input logic sdata_o
);
  logic [8:0] hi_run, lo_run;
  logic       seen_fall;
  logic       any_flag, rd_cmd;

  assign any_flag = cmd_valid_i | pcm_l_valid_i | pcm_r_valid_i | dig_a_valid_i | dig_b_valid_i;
  assign rd_cmd   = cmd_valid_i & cmd_read_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run    <= '0;
      lo_run    <= '0;
      seen_fall <= 1'b0;
    end else begin
      hi_run <= sync_o ? hi_run + 1'b1 : '0;
      lo_run <= sync_o ? '0 : lo_run + 1'b1;
      if (hi_run != 0 && !sync_o) seen_fall <= 1'b1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!sync_o && !sdata_o && !ready_o));

  a_r2_sync_high_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> hi_run == 9'd16);

  a_r2_sync_low_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sync_o) && seen_fall) |-> lo_run == 9'd240);

  a_r10_ready_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $rose(sync_o));

  a_r10_rise_has_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> ready_o);

  a_r4_valid_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |=> sdata_o == $past(any_flag, 2));

  a_r7_read_no_cdata_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sync_o) && $past(rd_cmd)) |=> ##2 !sdata_o);

  a_r5_tag_bit10_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |=> ##5 !sdata_o);

  a_r5_tag_bit9_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |=> ##6 !sdata_o);
endmodule

bind ac_link_tx ac_link_tx_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_valid_i   (cmd_valid_i),
  .cmd_read_i    (cmd_read_i),
  .pcm_l_valid_i (pcm_l_valid_i),
  .pcm_r_valid_i (pcm_r_valid_i),
  .dig_a_valid_i (dig_a_valid_i),
  .dig_b_valid_i (dig_b_valid_i),
  .ready_o       (ready_o),
  .sync_o        (sync_o),
  .sdata_o       (sdata_o)
);

// File: tb/ac_link_tx_bench.sv
`timescale 1ns/1ps
module ac_link_tx_bench;
  localparam int NF = 40;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cv, crd, lv, rv, av, bv;
  logic [6:0]  ca;
  logic [15:0] cd;
  logic [19:0] l, r, a, b;
  logic ready, sync, sdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit cur_f  [256];
  bit prev_f [256];

  always #5 clk = ~clk;

  ac_link_tx u_ac_link_tx (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cv), .cmd_read_i(crd), .cmd_addr_i(ca), .cmd_data_i(cd),
    .pcm_l_valid_i(lv), .pcm_l_i(l), .pcm_r_valid_i(rv), .pcm_r_i(r),
    .dig_a_valid_i(av), .dig_a_i(a), .dig_b_valid_i(bv), .dig_b_i(b),
    .ready_o(ready), .sync_o(sync), .sdata_o(sdata)
  );

  task automatic check(string req, logic act, logic exp, int e);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s edge %0d: actual %b expected %b", req, e, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(int f, int k);
    logic [31:0] x;
    x = (32'(f) * 32'h9E3779B1) ^ (32'(k) * 32'h85EBCA77);
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 12);
    return x;
  endfunction

  task automatic set_pattern(int f);
    ca = mix(f, 1)[6:0];  cd = mix(f, 2)[15:0];
    l  = mix(f, 3)[19:0]; r  = mix(f, 4)[19:0];
    a  = mix(f, 5)[19:0]; b  = mix(f, 6)[19:0];
    crd = 1'b0;
    case (f)
      0: {cv, lv, rv, av, bv} = 5'b00000;
      1: {cv, lv, rv, av, bv} = 5'b11111;
      2: begin {cv, lv, rv, av, bv} = 5'b11100; crd = 1'b1; end
      3: {cv, lv, rv, av, bv} = 5'b00001;
      4: {cv, lv, rv, av, bv} = 5'b01000;
      5: begin {cv, lv, rv, av, bv} = 5'b10000; ca = 7'h7F; cd = 16'hFFFF; end
      6: begin {cv, lv, rv, av, bv} = 5'b10010; crd = 1'b1; ca = 7'h00; end
      default: begin
        {cv, lv, rv, av, bv} = mix(f, 7)[4:0];
        crd = mix(f, 8)[0];
      end
    endcase
  endtask

  task automatic scramble();
    {cv, crd, lv, rv, av, bv} = 6'($urandom);
    ca = 7'($urandom); cd = 16'($urandom);
    l = 20'($urandom); r = 20'($urandom); a = 20'($urandom); b = 20'($urandom);
  endtask

  // reference frame: tag then twelve slots, first bit sent at index 0
  task automatic build_frame();
    bit q[$];
    logic [19:0] sv [1:12];
    logic [15:0] tg;
    tg = '0;
    tg[15] = cv | lv | rv | av | bv;
    tg[14] = cv;
    tg[13] = cv & ~crd;
    tg[12] = lv;
    tg[11] = rv;
    tg[8]  = av;
    tg[7]  = bv;
    for (int s = 1; s <= 12; s++) sv[s] = '0;
    if (cv) sv[1] = {crd, ca, 12'h000};
    if (cv && !crd) sv[2] = {cd, 4'h0};
    if (lv) sv[3] = l;
    if (rv) sv[4] = r;
    if (av) sv[7] = a;
    if (bv) sv[8] = b;
    for (int i = 15; i >= 0; i--) q.push_back(tg[i]);
    for (int s = 1; s <= 12; s++)
      for (int i = 19; i >= 0; i--) q.push_back(sv[s][i]);
    for (int i = 0; i < 256; i++) begin
      prev_f[i] = cur_f[i];
      cur_f[i]  = q[i];
    end
  endtask

  function automatic string label(int idx);
    int s;
    if (idx == 0) return "R3 R4";
    if (idx < 16) return "R5";
    s = (idx - 16) / 20 + 1;
    if (s == 1) return "R6";
    if (s == 2) return "R7";
    if (s == 3 || s == 4 || s == 7 || s == 8) return "R8";
    return "R9";
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) begin cur_f[i] = 0; prev_f[i] = 0; end
    set_pattern(0);
    repeat (3) @(negedge clk);
    check("R1", sync, 1'b0, 0);
    check("R1", sdata, 1'b0, 0);
    check("R1", ready, 1'b0, 0);
    rst_ni = 1'b1;
    for (int e = 1; e <= NF * 256 + 2; e++) begin
      int p, fc, idx;
      logic exp_sd;
      @(negedge clk);
      p  = (e - 1) % 256;
      fc = (e - 1) / 256;
      if (p == 0) build_frame();
      idx    = (p == 0) ? 255 : p - 1;
      exp_sd = (p == 0) ? prev_f[255] : cur_f[p - 1];
      check((e == 1) ? "R1" : "R2", sync, logic'(p < 16), e);
      check("R10", ready, logic'(p == 0), e);
      check(label(idx), sdata, exp_sd, e);
      if (p == 0) set_pattern(fc + 1);
      else if (p == 100) scramble();
      else if (p == 200) set_pattern(fc + 1);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule